// File: doc/BRIEF.md
# Selectable-Ratio Synchronous Clock Divider

The block derives a set of divided clocks from a single input clock and keeps every output edge that two outputs share in the same system cycle. One select input chooses the ratio set. With select low the outputs run at one half, one quarter and one eighth of the input clock. With select high they run at the input clock rate, one half of it and one quarter of it. All outputs come from one shared counter, so no output can drift against another.

The whole block runs on one fast system clock. The input clock arrives as an ordinary sampled signal, and a synchronizer with an edge detector finds its rising and falling edges. A hold control is captured only on input-clock falling edges. When it is high the counter stops, and when it is low the counter advances. Freezing and releasing therefore only happen while the input clock is low, so no output ever shows a shortened pulse. After a release the outputs carry on exactly where they stopped. An asynchronous, active-high master reset clears the counter and forces every output low at once. It is the means of putting several dividers into a known common phase after power-up. The system clock must run at least four times faster than the input clock.

Top module: `clk_div_sel`

## Requirements
- R1: While `mreset_i` is high, every bit of `div_o` is low, immediately and regardless of `src_clk_i`, `hold_i` and `ratio_sel_i`. After release, the count restarts from zero. `rst_ni` low also gives all-low outputs.
- R2: With the select latched low, after n counted input rising edges `div_o[i]` equals bit i of n mod 8. Output i therefore divides the input clock by 2^(i+1).
- R3: With the select latched high, `div_o[0]` follows the input clock level while not held, `div_o[1]` equals bit 0 of n and `div_o[2]` equals bit 1 of n. Output i therefore divides by 2^i.
- R4: When a counted rising edge changes several outputs, all of them change in the same system clock cycle. The edge appears on the outputs within four system cycles of the input edge.
- R5: `hold_i` is sampled only on input-clock falling edges. A pulse on `hold_i` that starts and ends between two falling edges has no effect.
- R6: While the latched hold is high, rising input edges are not counted and the outputs keep their values. The divide-by-1 output stays low.
- R7: After the hold is released, counting resumes from the frozen count, so the outputs continue the sequence that was interrupted.
- R8: A change of `ratio_sel_i` takes effect at the next input rising edge. The count is kept across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the input clock rate |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| src_clk_i | input | 1 | Input clock to divide, sampled on clk_i |
| ratio_sel_i | input | 1 | Ratio set: 0 gives /2,/4,/8; 1 gives /1,/2,/4 |
| hold_i | input | 1 | High freezes the dividers; captured on input falling edges |
| mreset_i | input | 1 | Active-high asynchronous master reset of the divider |
| div_o | output | NUM_OUT | Divided clocks; bit i is the i-th ratio of the selected set |

## Verification
The bench drives the 3-to-4 count step in the low-ratio set, where all three outputs flip at once. A design whose stages ripple, or that took one output from a separately delayed path, would show an intermediate value there. A short hold pulse placed entirely inside a high phase catches a design that samples the hold on a level instead of on a falling edge, because such a design would lose counts. Freeze and release are exercised in both ratio sets. A design that cleared or skipped state would break the continued sequence, and a badly gated divide-by-1 output would show a pulse while frozen. The tests also switch the select in a low phase and assert master reset in the middle of a run. A design that reset the count on a select change, applied the new select too early, or waited for a clock before clearing would each give the wrong outputs at those points.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef struct packed {
    logic level;  // delayed input clock level, aligned with counter update
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/cdiv_edge.sv
module cdiv_edge
  import cdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  src_i,
  output edge_t edge_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], src_i};
      last_q <= sync_q[MSB];
    end
  end

  assign edge_o.level = last_q;
  assign edge_o.rise  = sync_q[MSB] & ~last_q;
  assign edge_o.fall  = ~sync_q[MSB] & last_q;
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
  import cdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arst_ni,
  input  edge_t            edge_i,
  input  logic             hold_i,
  input  logic             sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hold_o,
  output logic             sel_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;
  logic             sel_q;

  // hold captured on falling edge only: freeze/unfreeze while input is low
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (edge_i.fall) hold_q <= hold_i;
      if (edge_i.rise && !hold_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  // select survives master reset; count is kept across a ratio change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else if (edge_i.rise) sel_q <= sel_i;
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/cdiv_out.sv
module cdiv_out #(
  parameter int unsigned NUM_OUT = 3
) (
  input  logic               clk_i,
  input  logic               arst_ni,
  input  logic [NUM_OUT-1:0] cnt_i,
  input  logic               sel_i,
  input  logic               level_i,
  input  logic               hold_i,
  output logic [NUM_OUT-1:0] div_o
);
  logic [NUM_OUT-1:0] div_q;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    logic fast;
    if (i == 0) begin : g_pass
      assign fast = level_i & ~hold_i;
    end else begin : g_cnt
      assign fast = cnt_i[i-1];
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) div_q[i] <= 1'b0;
      else          div_q[i] <= sel_i ? fast : cnt_i[i];
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/clk_div_sel.sv
module clk_div_sel
  import cdiv_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_clk_i,
  input  logic               ratio_sel_i,
  input  logic               hold_i,
  input  logic               mreset_i,
  output logic [NUM_OUT-1:0] div_o
);
  localparam int unsigned CNT_W = NUM_OUT;

  edge_t            edge_s;
  logic             core_rst_n;
  logic [CNT_W-1:0] cnt_w;
  logic             hold_w;
  logic             sel_w;
  logic             rise_w;
  logic             fall_w;

  assign core_rst_n = rst_ni & ~mreset_i;
  assign rise_w     = edge_s.rise;
  assign fall_w     = edge_s.fall;

  cdiv_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_clk_i),
    .edge_o (edge_s)
  );

  cdiv_core #(.CNT_W(CNT_W)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arst_ni (core_rst_n),
    .edge_i  (edge_s),
    .hold_i  (hold_i),
    .sel_i   (ratio_sel_i),
    .cnt_o   (cnt_w),
    .hold_o  (hold_w),
    .sel_o   (sel_w)
  );

  cdiv_out #(.NUM_OUT(NUM_OUT)) i_out (
    .clk_i   (clk_i),
    .arst_ni (core_rst_n),
    .cnt_i   (cnt_w),
    .sel_i   (sel_w),
    .level_i (edge_s.level),
    .hold_i  (hold_w),
    .div_o   (div_o)
  );
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int unsigned N = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mreset_i,
  input logic         rise_i,
  input logic         fall_i,
  input logic         hold_i,
  input logic         sel_i,
  input logic [N-1:0] cnt_i,
  input logic [N-1:0] div_i
);
  logic sel_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_d <= 1'b0;
    else         sel_d <= sel_i;
  end

  AST_MRESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |-> (div_i == '0));  // R1

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || mreset_i)
    (rise_i && !hold_i) |=> (cnt_i == N'($past(cnt_i) + 1'b1)));  // R2

  AST_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni || mreset_i)
    (!$stable(div_i[N-1]) && $stable(sel_d)) |-> !$stable(div_i[N-2]));  // R4

  AST_HOLD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni || mreset_i)
    !fall_i |=> $stable(hold_i));  // R5

  AST_FREEZE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni || mreset_i)
    hold_i |=> $stable(cnt_i));  // R6

  AST_FAST_LOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni || mreset_i)
    (sel_i && hold_i) |=> !div_i[0]);  // R6

  AST_SEL_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(sel_i));  // R8
endmodule

bind clk_div_sel cdiv_checker #(.N(NUM_OUT)) i_cdiv_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mreset_i (mreset_i),
  .rise_i   (rise_w),
  .fall_i   (fall_w),
  .hold_i   (hold_w),
  .sel_i    (sel_w),
  .cnt_i    (cnt_w),
  .div_i    (div_o)
);

// File: tb/test_clk_div_sel.sv
module test_clk_div_sel;
  localparam int HALF    = 6;
  localparam int TIMEOUT = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src = 1'b0;
  logic       sel = 1'b0;
  logic       hold = 1'b0;
  logic       mrst = 1'b0;
  logic [2:0] div;

  int vectors = 0;
  int fails   = 0;

  // reference model state
  int unsigned n_m   = 0;
  logic        hold_m = 1'b0;
  logic        sel_m  = 1'b0;
  logic        mr_m   = 1'b0;

  always #2.5 clk = ~clk;

  clk_div_sel i_clk_div_sel (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_clk_i   (src),
    .ratio_sel_i (sel),
    .hold_i      (hold),
    .mreset_i    (mrst),
    .div_o       (div)
  );

  function automatic logic [2:0] exp_q();
    logic [2:0] c;
    c = n_m[2:0];
    if (mr_m)        return 3'b000;
    else if (!sel_m) return c;
    else             return {c[1], c[0], src & ~hold_m};
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: div_o=%b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive_edge(logic lvl);
    src = lvl;
    if (lvl) begin
      sel_m = sel;
      if (!mr_m && !hold_m) n_m++;
    end else if (!mr_m) begin
      hold_m = hold;
    end
  endtask

  task automatic half(logic lvl, string req);
    drive_edge(lvl);
    repeat (HALF) @(negedge clk);
    check(req, div, exp_q());
  endtask

  task automatic cycles(int k, string req);
    for (int i = 0; i < k; i++) begin
      half(1'b1, req);
      half(1'b0, req);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset", div, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", div, 3'b000);
  endtask

  task automatic t_low_set();
    cycles(18, "R2");
  endtask

  task automatic t_align();
    logic [2:0] prev;
    logic [2:0] exp;
    bit         seen;
    while (n_m % 8 != 3) cycles(1, "R2");
    prev = div;
    drive_edge(1'b1);
    exp  = exp_q();
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!seen && div !== prev) begin
        seen = 1;
        check("R4 single step", div, exp);
      end
    end
    if (!seen) check("R4 latency", div, exp);
    repeat (HALF - 4) @(negedge clk);
    check("R4", div, exp);
    half(1'b0, "R4");
  endtask

  task automatic t_hold_pulse();
    // pulse entirely inside a high phase: no falling edge sees it
    drive_edge(1'b1);
    repeat (2) @(negedge clk);
    hold = 1'b1;
    repeat (2) @(negedge clk);
    hold = 1'b0;
    repeat (2) @(negedge clk);
    check("R5", div, exp_q());
    half(1'b0, "R5");
    cycles(3, "R5");
  endtask

  task automatic t_freeze(string tag);
    logic [2:0] frozen;
    half(1'b1, tag);
    hold = 1'b1;
    half(1'b0, "R6");
    frozen = div;
    for (int i = 0; i < 4; i++) begin
      half(1'b1, "R6");
      check("R6 steady", div, frozen);
      half(1'b0, "R6");
    end
    hold = 1'b0;
    half(1'b1, "R6");
    half(1'b0, "R7");
    cycles(6, "R7");
  endtask

  task automatic t_sel_change();
    half(1'b1, "R8");
    sel = 1'b1;
    half(1'b0, "R8 before rise");
    cycles(8, "R3");
  endtask

  task automatic t_mreset();
    cycles(3, "R3");
    half(1'b1, "R3");
    mrst = 1'b1;
    mr_m = 1'b1;
    #1;
    check("R1 async", div, 3'b000);
    hold = 1'b1;
    half(1'b0, "R1");
    half(1'b1, "R1");
    hold = 1'b0;
    half(1'b0, "R1");
    mrst   = 1'b0;
    mr_m   = 1'b0;
    n_m    = 0;
    hold_m = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 release", div, 3'b000);
    cycles(5, "R1");
    sel = 1'b0;
    cycles(5, "R8");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(TIMEOUT * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_low_set();
    t_align();
    t_hold_pulse();
    t_freeze("R2");
    t_sel_change();
    t_freeze("R3");
    t_mreset();
    summary();
  end
endmodule